// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple host request port and an asynchronous fast-page-mode DRAM. The DRAM has a 12-bit row, a 10-bit column and a 16-bit data path made of two byte lanes. Each accepted request is a word or byte read or write. The controller turns it into a sequence of row strobe, per-lane column strobe, write enable and output enable levels. Row and column share one multiplexed address bus, and every timing interval is a parameter counted in clock cycles.

After an access the row stays open. A later request to the same row starts a new column cycle at once, with no new row strobe. A request to another row, a refresh request, or a row-active time close to its cap closes the row and waits out a full precharge before anything else happens. A refresh scheduler raises a request line. The controller closes any open row and runs a column-before-row refresh cycle. It then acknowledges with a one-cycle pulse and holds off the host for as long as the request is high.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During reset and right after it, the row strobe, both column strobes, write enable and output enable are high (inactive), `dram_dq_oe` is 0, `rd_valid` is 0, `busy` is 0 and `req_ready` is 1.
- R2: The row field is `req_addr[21:10]` and the column field is `req_addr[9:0]`. The row sits on `dram_addr` while the row strobe falls. The column (zero-extended) sits on `dram_addr` for at least one full cycle before a column strobe falls. The row strobe has been low for at least one cycle before any access column strobe falls.
- R3: A request to the row that is already open is served without raising the row strobe. Between two column cycles of one page the column strobes stay high for at least `T_CP` cycles.
- R4: A request to a row other than the open one raises the row strobe. The row strobe then stays high for at least `T_RP` cycles before the next row is opened.
- R5: `req_be[0]` selects the lower lane (`dram_cas_n[0]`, data bits 7:0) and `req_be[1]` selects the upper lane (`dram_cas_n[1]`, bits 15:8). A write changes only the enabled bytes of the addressed location.
- R6: Writes are early writes. Write enable and `dram_dq_oe` are set at least one cycle before the column strobe falls, output enable stays high, and write enable does not change while a column strobe is low.
- R7: For a read, output enable is low and write enable is high. The data is sampled `max(T_CASW,T_RD)` cycles after the column strobe falls and returned with a one-cycle `rd_valid` pulse. Bytes whose lane is not enabled read as zero. Read results come back in request order.
- R8: The row strobe never stays low for more than `RAS_MAX_CYC` consecutive cycles. A row that reaches its age limit is closed and opened again by the next request.
- R9: While `ref_req` is high, `req_ready` is low. The open row is closed and precharged. Then both column strobes fall one cycle before the row strobe falls, with write enable high. After `T_RAS_MIN` cycles both strobes rise and `ref_ack` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted on this edge when valid is also high |
| req_addr | input | 22 | Word address: row in 21:10, column in 9:0 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables (bit 0 lower, bit 1 upper) |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data, disabled lanes zero |
| ref_req | input | 1 | Refresh request from the scheduler, held until acknowledged |
| ref_ack | output | 1 | One-cycle pulse after a refresh cycle |
| busy | output | 1 | Controller not idle with the row closed |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Write data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Read data from the DRAM |

## Verification
The hardest case to reach is a forced close when the row-age cap expires in the middle of a stream of page hits. The close must happen with no miss and no refresh present, and the data must stay intact across the reopen. The bench builds the controller with a short cap of 80 cycles and sends a run of writes, then reads, all to one row. The sequence lasts far longer than the cap, so the controller has to close and reopen the row several times. Refresh is requested while a row is still open, so the bench also covers the close, the precharge and the strobe order of the refresh cycle itself.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,   // row closed and precharged
      ST_RCD,    // row strobe low, row address held
      ST_SET,    // column address and write enable settle
      ST_CAS,    // column strobe low
      ST_OPEN,   // row open, column strobes high
      ST_PRE,    // row strobe high, precharge
      ST_RFC,    // refresh: column strobes low first
      ST_RFR     // refresh: row strobe low
   } fpm_state_e;

endpackage

// File: rtl/fpm_row_track.sv
module fpm_row_track #(
   parameter int ROW_W       = 12,
   parameter int RAS_MAX_CYC = 6000,
   parameter int GUARD       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_i,
   input  logic             close_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             hit_o,
   output logic             expire_o
);
   localparam int AW     = $clog2(RAS_MAX_CYC + 1);
   localparam int EXP_AT = RAS_MAX_CYC - GUARD;

   logic [ROW_W-1:0] row_q;
   logic             valid_q;
   logic [AW-1:0]    age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q   <= '0;
         valid_q <= 1'b0;
         age_q   <= '0;
      end else if (open_i) begin
         row_q   <= row_i;
         valid_q <= 1'b1;
         age_q   <= '0;
      end else if (close_i) begin
         valid_q <= 1'b0;
         age_q   <= '0;
      end else if (valid_q) begin
         age_q   <= age_q + 1'b1;
      end
   end

   assign hit_o    = valid_q && (row_q == row_i);
   assign expire_o = valid_q && (age_q >= AW'(EXP_AT));

   assert_ras_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (age_q < AW'(RAS_MAX_CYC)));

endmodule

// File: rtl/fpm_lane.sv
module fpm_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe_i,
   input  logic         en_i,
   input  logic         capture_i,
   input  logic [W-1:0] dq_i,
   output logic         cas_n_o,
   output logic [W-1:0] rdata_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdata_o <= '0;
      else if (capture_i) rdata_o <= en_i ? dq_i : '0;
   end

   assign cas_n_o = ~(strobe_i & en_i);

   assert_lane_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_i && !en_i) |=> (rdata_o == '0));

endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
   import fpm_dram_pkg::*;
#(
   parameter int ROW_W     = 12,
   parameter int COL_W     = 10,
   parameter int DATA_W    = 16,
   parameter int T_RCD     = 1,
   parameter int T_CASW    = 1,
   parameter int T_CP      = 1,
   parameter int T_RP      = 2,
   parameter int T_RD      = 3,
   parameter int T_RAS_MIN = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid,
   input  logic [ROW_W+COL_W-1:0]           req_addr,
   input  logic                             req_we,
   input  logic [DATA_W/8-1:0]              req_be,
   input  logic [DATA_W-1:0]                req_wdata,
   output logic                             req_ready,
   input  logic                             ref_req,
   output logic                             ref_ack,
   output logic                             busy,
   input  logic                             row_hit,
   input  logic                             row_expire,
   output logic                             row_open,
   output logic                             row_close,
   output logic                             ras_n,
   output logic                             cas_act,
   output logic [DATA_W/8-1:0]              be_q,
   output logic                             we_n,
   output logic                             oe_n,
   output logic                             dq_oe,
   output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] addr_q,
   output logic [DATA_W-1:0]                wdata_q,
   output logic                             capture,
   output logic                             rd_valid
);
   localparam int ADDR_W = ROW_W + COL_W;
   localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int RDL    = (T_RD > T_CASW) ? T_RD : T_CASW;
   localparam int M1     = (T_RCD > RDL) ? T_RCD : RDL;
   localparam int M2     = (T_CP > T_RP) ? T_CP : T_RP;
   localparam int M3     = (M1 > M2) ? M1 : M2;
   localparam int CMAX   = (M3 > T_RAS_MIN) ? M3 : T_RAS_MIN;
   localparam int CW     = $clog2(CMAX + 1);
   localparam int HW     = $clog2(T_RP + 1) + 1;

   fpm_state_e           state_q;
   logic [CW-1:0]        cnt_q;
   logic                 we_q;
   logic [COL_W-1:0]     col_q;
   logic                 cnt_zero, idle_take, open_take;
   logic [ROW_W-1:0]     req_row;
   logic [COL_W-1:0]     req_col;
   logic [HW-1:0]        hi_run;

   assign req_row = req_addr[ADDR_W-1:COL_W];
   assign req_col = req_addr[COL_W-1:0];

   always_comb begin
      cnt_zero  = (cnt_q == '0);
      idle_take = (state_q == ST_IDLE) && !ref_req;
      open_take = (state_q == ST_OPEN) && cnt_zero && !ref_req && !row_expire && row_hit;
      req_ready = idle_take || open_take;
      row_open  = idle_take && req_valid;
      row_close = (state_q == ST_OPEN) && cnt_zero &&
                  (ref_req || row_expire || (req_valid && !row_hit));
      capture   = (state_q == ST_CAS) && cnt_zero && !we_q;
      busy      = (state_q != ST_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         ras_n    <= 1'b1;
         cas_act  <= 1'b0;
         be_q     <= '0;
         we_n     <= 1'b1;
         oe_n     <= 1'b1;
         dq_oe    <= 1'b0;
         addr_q   <= '0;
         wdata_q  <= '0;
         we_q     <= 1'b0;
         col_q    <= '0;
         rd_valid <= 1'b0;
         ref_ack  <= 1'b0;
      end else begin
         rd_valid <= capture;
         ref_ack  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (ref_req) begin
                  state_q <= ST_RFC;
                  cas_act <= 1'b1;
                  be_q    <= '1;
                  we_n    <= 1'b1;
                  oe_n    <= 1'b1;
                  cnt_q   <= '0;
               end else if (req_valid) begin
                  state_q <= ST_RCD;
                  ras_n   <= 1'b0;
                  addr_q  <= MUX_W'(req_row);
                  col_q   <= req_col;
                  we_q    <= req_we;
                  be_q    <= req_be;
                  wdata_q <= req_wdata;
                  cnt_q   <= CW'(T_RCD - 1);
               end
            end
            ST_RCD: begin
               if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
               else begin
                  state_q <= ST_SET;
                  addr_q  <= MUX_W'(col_q);
                  we_n    <= !we_q;
                  oe_n    <= we_q;
                  dq_oe   <= we_q;
               end
            end
            ST_SET: begin
               state_q <= ST_CAS;
               cas_act <= 1'b1;
               cnt_q   <= we_q ? CW'(T_CASW - 1) : CW'(RDL - 1);
            end
            ST_CAS: begin
               if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
               else begin
                  state_q <= ST_OPEN;
                  cas_act <= 1'b0;
                  we_n    <= 1'b1;
                  oe_n    <= 1'b1;
                  dq_oe   <= 1'b0;
                  cnt_q   <= CW'(T_CP - 1);
               end
            end
            ST_OPEN: begin
               if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
               else if (row_close) begin
                  state_q <= ST_PRE;
                  ras_n   <= 1'b1;
                  cnt_q   <= CW'(T_RP - 1);
               end else if (req_valid && open_take) begin
                  state_q <= ST_SET;
                  addr_q  <= MUX_W'(req_col);
                  we_q    <= req_we;
                  be_q    <= req_be;
                  wdata_q <= req_wdata;
                  we_n    <= !req_we;
                  oe_n    <= req_we;
                  dq_oe   <= req_we;
               end
            end
            ST_PRE: begin
               if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
               else state_q <= ST_IDLE;
            end
            ST_RFC: begin
               state_q <= ST_RFR;
               ras_n   <= 1'b0;
               cnt_q   <= CW'(T_RAS_MIN - 1);
            end
            ST_RFR: begin
               if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
               else begin
                  state_q <= ST_PRE;
                  ras_n   <= 1'b1;
                  cas_act <= 1'b0;
                  ref_ack <= 1'b1;
                  cnt_q   <= CW'(T_RP - 1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Length of the current row-strobe-high run, saturating; starts full after reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   hi_run <= HW'(T_RP);
      else if (!ras_n)              hi_run <= '0;
      else if (hi_run < HW'(T_RP))  hi_run <= hi_run + 1'b1;
   end

   assert_cas_after_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cas_act) && !ras_n) |-> $past(!ras_n));
   assert_col_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_act) |-> $stable(addr_q));
   assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (hi_run >= HW'(T_RP)));
   assert_early_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_act) |-> $stable(we_n));
   assert_we_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_act && $past(cas_act)) |-> $stable(we_n));
   assert_rd_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!oe_n && we_n));
   assert_cbr_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && cas_act) |-> $past(cas_act));
   assert_ack_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_ack |-> (ras_n && !cas_act));

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
   parameter int ROW_W       = 12,
   parameter int COL_W       = 10,
   parameter int DATA_W      = 16,
   parameter int T_RCD       = 1,
   parameter int T_CASW      = 1,
   parameter int T_CP        = 1,
   parameter int T_RP        = 2,
   parameter int T_RD        = 3,
   parameter int T_RAS_MIN   = 3,
   parameter int RAS_MAX_CYC = 6000
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   output logic                                   req_ready,
   input  logic [ROW_W+COL_W-1:0]                 req_addr,
   input  logic                                   req_we,
   input  logic [DATA_W/8-1:0]                    req_be,
   input  logic [DATA_W-1:0]                      req_wdata,
   output logic                                   rd_valid,
   output logic [DATA_W-1:0]                      rd_data,
   input  logic                                   ref_req,
   output logic                                   ref_ack,
   output logic                                   busy,
   output logic                                   dram_ras_n,
   output logic [DATA_W/8-1:0]                    dram_cas_n,
   output logic                                   dram_we_n,
   output logic                                   dram_oe_n,
   output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
   output logic [DATA_W-1:0]                      dram_dq_out,
   output logic                                   dram_dq_oe,
   input  logic [DATA_W-1:0]                      dram_dq_in
);
   localparam int LANES  = DATA_W / 8;
   localparam int ADDR_W = ROW_W + COL_W;
   localparam int RDL    = (T_RD > T_CASW) ? T_RD : T_CASW;
   localparam int GUARD  = T_CASW + RDL + T_CP + 2;

   initial begin
      assert (DATA_W % 8 == 0 && LANES >= 1) else $error("DATA_W must be whole bytes");
      assert (T_RCD >= 1 && T_CASW >= 1 && T_CP >= 1 && T_RP >= 1 && T_RD >= 1)
         else $error("timing counts must be at least one cycle");
      assert (T_RAS_MIN >= 1 && T_RAS_MIN <= T_RCD + T_CASW + T_CP + 2)
         else $error("T_RAS_MIN not met by the shortest access");
      assert (RAS_MAX_CYC > 2 * GUARD + T_RCD) else $error("RAS_MAX_CYC too small");
   end

   logic             row_hit, row_expire, row_open, row_close;
   logic             cas_act, capture;
   logic [LANES-1:0] be_q;

   fpm_seq #(
      .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
      .T_RCD(T_RCD), .T_CASW(T_CASW), .T_CP(T_CP), .T_RP(T_RP),
      .T_RD(T_RD), .T_RAS_MIN(T_RAS_MIN)
   ) seq_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we),
      .req_be(req_be), .req_wdata(req_wdata), .req_ready(req_ready),
      .ref_req(ref_req), .ref_ack(ref_ack), .busy(busy),
      .row_hit(row_hit), .row_expire(row_expire),
      .row_open(row_open), .row_close(row_close),
      .ras_n(dram_ras_n), .cas_act(cas_act), .be_q(be_q),
      .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe),
      .addr_q(dram_addr), .wdata_q(dram_dq_out),
      .capture(capture), .rd_valid(rd_valid)
   );

   fpm_row_track #(
      .ROW_W(ROW_W), .RAS_MAX_CYC(RAS_MAX_CYC), .GUARD(GUARD)
   ) track_i (
      .clk(clk), .rst_n(rst_n),
      .open_i(row_open), .close_i(row_close),
      .row_i(req_addr[ADDR_W-1:COL_W]),
      .hit_o(row_hit), .expire_o(row_expire)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      fpm_lane #(.W(8)) lane_i (
         .clk(clk), .rst_n(rst_n),
         .strobe_i(cas_act), .en_i(be_q[g]), .capture_i(capture),
         .dq_i(dram_dq_in[g*8 +: 8]),
         .cas_n_o(dram_cas_n[g]),
         .rdata_o(rd_data[g*8 +: 8])
      );
   end

endmodule

// File: tb/fpm_dram_ctrl_tb_top.sv
module fpm_dram_ctrl_tb_top;
   localparam int RMAX = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
   logic [21:0] req_addr = '0;
   logic [1:0]  req_be = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready, rd_valid, ref_ack, busy;
   logic [15:0] rd_data, dq_out, dq_in;
   logic        ras_n, we_n, oe_n, dq_oe;
   logic [1:0]  cas_n;
   logic [11:0] dram_addr;

   always #10 clk = ~clk;

   fpm_dram_ctrl #(.RAS_MAX_CYC(RMAX)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_ack(ref_ack),
      .busy(busy), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
      .dram_oe_n(oe_n), .dram_addr(dram_addr), .dram_dq_out(dq_out),
      .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
   );

   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- DRAM model, sampled at the falling clock edge ----------------
   logic [15:0] mem [int];
   logic [15:0] m_word = '0;
   logic [11:0] m_row = '0;
   logic        p_ras = 1'b1, p_we = 1'b1;
   logic [1:0]  p_cas = 2'b11;
   int ras_falls = 0, cbr_cnt = 0, cbr_bad = 0, wr_viol = 0;
   int lo_run = 0, lo_max = 0, hi_run = 1000, hi_min = 1000;
   int exp_wr_q [$];
   int exp_rd_q [$];

   assign dq_in = {(!cas_n[1] && !oe_n && we_n) ? m_word[15:8] : 8'h00,
                   (!cas_n[0] && !oe_n && we_n) ? m_word[7:0]  : 8'h00};

   always @(negedge clk) begin
      automatic logic [1:0] fall = p_cas & ~cas_n;
      if (p_ras && !ras_n) begin
         ras_falls++;
         if (hi_run < hi_min) hi_min = hi_run;
         if (cas_n == 2'b00) begin
            cbr_cnt++;
            if (p_cas != 2'b00 || !we_n) cbr_bad++;
         end else begin
            m_row = dram_addr;
         end
      end
      if (!ras_n) begin lo_run++; hi_run = 0; if (lo_run > lo_max) lo_max = lo_run; end
      else begin lo_run = 0; hi_run++; end
      if (fall != 2'b00 && !ras_n && p_ras == 1'b0) begin
         automatic int key = int'({m_row, dram_addr[9:0]});
         automatic logic [15:0] cur = mem.exists(key) ? mem[key] : 16'h0;
         if (!we_n) begin
            if (!oe_n || !dq_oe || p_we) wr_viol++;
            if (fall[0]) cur[7:0]  = dq_out[7:0];
            if (fall[1]) cur[15:8] = dq_out[15:8];
            mem[key] = cur;
            if (exp_wr_q.size() == 0) chk(1'b0, "R2 unexpected write", key, 0);
            else begin
               automatic int e = exp_wr_q.pop_front();
               chk(key == e, "R2 write row/column", key, e);
            end
         end
         m_word = cur;
      end
      if (cas_n != 2'b11 && p_cas != 2'b11 && !ras_n && we_n != p_we) wr_viol++;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
   end

   // ---------------- read monitor (scoreboard) ----------------
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_rd_q.size() == 0) chk(1'b0, "R7 unexpected read data", rd_data, 0);
         else begin
            automatic int e = exp_rd_q.pop_front();
            chk(rd_data == e[15:0], "R7/R5 read data", rd_data, e);
         end
      end
   end

   // ---------------- driver ----------------
   logic [15:0] shadow [int];

   task automatic issue(input logic [21:0] a, input bit w, input logic [1:0] be, input logic [15:0] d);
      automatic int k = int'(a);
      automatic logic [15:0] cur = shadow.exists(k) ? shadow[k] : 16'h0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_we = w; req_be = be; req_wdata = d;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      if (w) begin
         if (be[0]) cur[7:0]  = d[7:0];
         if (be[1]) cur[15:8] = d[15:8];
         shadow[k] = cur;
         exp_wr_q.push_back(k);
      end else begin
         exp_rd_q.push_back(int'({be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00}));
      end
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int f0;
      bit rdy_seen, acked;
      repeat (4) @(negedge clk);
      chk({ras_n, cas_n, we_n, oe_n, dq_oe, req_ready, busy, rd_valid} == 9'b111110100,
          "R1 reset state", {ras_n, cas_n, we_n, oe_n, dq_oe, req_ready, busy, rd_valid}, 9'b111110100);
      rst_n = 1'b1;
      @(negedge clk);
      chk({ras_n, cas_n, req_ready, busy} == 5'b11110, "R1 after reset",
          {ras_n, cas_n, req_ready, busy}, 5'b11110);

      // R3: page writes and reads in row 5
      f0 = ras_falls;
      issue({12'd5, 10'd1}, 1'b1, 2'b11, 16'h1234);
      issue({12'd5, 10'd2}, 1'b1, 2'b11, 16'hBEEF);
      issue({12'd5, 10'd3}, 1'b1, 2'b11, 16'h0F0F);
      issue({12'd5, 10'd1}, 1'b0, 2'b11, 16'h0);
      issue({12'd5, 10'd2}, 1'b0, 2'b11, 16'h0);
      settle(8);
      chk(ras_falls - f0 == 1, "R3 page hits open row once", ras_falls - f0, 1);

      // R5: byte writes then word and byte reads
      issue({12'd5, 10'd2}, 1'b1, 2'b01, 16'hAA55);
      issue({12'd5, 10'd3}, 1'b1, 2'b10, 16'hC3FF);
      issue({12'd5, 10'd2}, 1'b0, 2'b11, 16'h0);
      issue({12'd5, 10'd3}, 1'b0, 2'b11, 16'h0);
      issue({12'd5, 10'd3}, 1'b0, 2'b01, 16'h0);
      issue({12'd5, 10'd2}, 1'b0, 2'b10, 16'h0);

      // R4: row miss and return
      f0 = ras_falls;
      issue({12'd9, 10'd7}, 1'b1, 2'b11, 16'h9999);
      issue({12'd5, 10'd1}, 1'b0, 2'b11, 16'h0);
      issue({12'd9, 10'd7}, 1'b0, 2'b11, 16'h0);
      settle(8);
      chk(ras_falls - f0 == 3, "R4 each row miss reopens", ras_falls - f0, 3);

      // R8: long page stream in row 7
      f0 = ras_falls;
      for (int i = 0; i < 24; i++) issue({12'd7, 10'(i)}, 1'b1, 2'b11, 16'(i * 16'h0111 + 16'h7));
      for (int i = 0; i < 24; i++) issue({12'd7, 10'(i)}, 1'b0, 2'b11, 16'h0);
      settle(10);
      chk(ras_falls - f0 >= 3, "R8 row reopened after age cap", ras_falls - f0, 3);
      chk(lo_max <= RMAX, "R8 longest row strobe low run", lo_max, RMAX);
      settle(RMAX + 20);
      chk(busy == 1'b0 && ras_n == 1'b1, "R8 idle row closed by cap", {busy, ras_n}, 2'b01);

      // R9: refresh while a row is open
      issue({12'd3, 10'd4}, 1'b1, 2'b11, 16'h5A5A);
      settle(2);
      f0 = cbr_cnt;
      @(negedge clk); ref_ack_wait: begin
         ref_req = 1'b1;
         rdy_seen = 1'b0; acked = 1'b0;
         for (int i = 0; i < 40 && !acked; i++) begin
            @(negedge clk); #1;
            if (req_ready) rdy_seen = 1'b1;
            if (ref_ack) acked = 1'b1;
         end
         ref_req = 1'b0;
      end
      chk(acked, "R9 refresh acknowledged", acked, 1);
      chk(!rdy_seen, "R9 host held off during refresh", rdy_seen, 0);
      chk(cbr_cnt - f0 == 1, "R9 one refresh cycle", cbr_cnt - f0, 1);
      chk(cbr_bad == 0, "R9 column strobes lead row strobe", cbr_bad, 0);
      issue({12'd3, 10'd4}, 1'b0, 2'b11, 16'h0);
      issue({12'd7, 10'd5}, 1'b0, 2'b11, 16'h0);
      settle(20);

      chk(hi_min >= 2, "R4 shortest precharge", hi_min, 2);
      chk(wr_viol == 0, "R6 early write discipline", wr_viol, 0);
      chk(exp_rd_q.size() == 0, "R7 all reads returned", exp_rd_q.size(), 0);
      chk(exp_wr_q.size() == 0, "R2 all writes reached the array", exp_wr_q.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule